// File: doc/BRIEF.md
# Two-Wire Trim Register Slave

This block is a two-wire serial bus slave (I2C-compatible) that owns a 6-bit trim code and can request its permanent programming. The bus lines are sampled in the system clock domain through synchronizers. The block finds START and STOP conditions and matches its 7-bit address. It acknowledges the bytes it accepts and drives SDA open-drain through an output-enable. A pin strap supplies the low address bit, so two of these slaves can share one bus.

A write transaction is made of the address byte, then one instruction byte, then any number of data bytes. Each data byte loads the trim code again under that one instruction. The top bit of the instruction requests permanent programming. The request is raised once, after the first data byte that follows it has been written. A read transaction returns one byte: the two validation status bits sit above the current trim code. Once the external programming flow reports that it has completed, data bytes still get an acknowledge but no longer change the code.

Top module: `trim_i2c_slave`

## Requirements
- R1: The slave accepts only the address byte whose seven upper bits are 0101100 or 0101101, where bit 1 equals `addr_sel` and bit 0 is the direction (1 = read). Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: For each accepted address, instruction and data byte, the slave pulls SDA low (`sda_oe` = 1) during the 9th clock. It changes `sda_oe` only after SCL has gone low.
- R3: In a write, the low six bits of a data byte become `trim_code`. `wr_stb` pulses for one cycle in the cycle `trim_code` takes the new value. Data bits 7:6 and instruction bits 6:0 have no effect on the code.
- R4: Every further data byte in the same write transaction loads `trim_code` again and gives another `wr_stb` pulse, until STOP.
- R5: After a read address is acknowledged, the slave shifts out one byte MSB first: bit 7 is `status_i[1]`, bit 6 is `status_i[0]`, and bits 5:0 are `trim_code`. A master NACK ends the read. Repeated read transactions are served.
- R6: When instruction bit 7 is 1, `otp_start` pulses for exactly one cycle, once per transaction. The pulse comes after the first following data byte has been written and acknowledged, and never together with or before that byte's `wr_stb`.
- R7: While `prog_done_i` is 1, data bytes leave `trim_code` unchanged and produce neither `wr_stb` nor `otp_start`.
- R8: A START or STOP in the middle of a byte abandons the transaction and updates nothing. After a repeated START, the next byte is taken as an address.
- R9: After reset `trim_code` is 0x20 (midscale), and `sda_oe`, `wr_stb` and `otp_start` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_sel | input | 1 | Strapped low address bit |
| status_i | input | 2 | Validation status bits returned in a read |
| prog_done_i | input | 1 | Permanent programming has completed |
| sda_oe | output | 1 | Pull SDA low when 1 |
| trim_code | output | 6 | Current trim code |
| wr_stb | output | 1 | One-cycle pulse when trim_code is loaded |
| otp_start | output | 1 | One-cycle request to start permanent programming |

## Verification
Writes are driven with a matching address and with the neighbouring address. This tells the pin-strap compare apart from a compare on the fixed prefix alone. Data bytes with both ignored bits set, and an instruction byte with its low seven bits all ones, show that only the intended bits reach the code. A three-byte stream and a two-byte stream under a programming instruction tell per-byte loading apart from a single load per transaction, and a single launch apart from one launch per byte. Aborts by repeated START and by STOP part-way through a byte show that no partial byte is ever written. Reads with two status values, taken before and after the lock, check the packing order.

// File: rtl/trim_i2c_pkg.sv
package trim_i2c_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_INSTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_TX_ACK
  } frame_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/trim_i2c_line_sync.sv
module trim_i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_s;

  // bus idles high, so the pipes reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/trim_i2c_frame.sv
module trim_i2c_frame
  import trim_i2c_pkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b010110,
  parameter int unsigned CODE_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                addr_sel,
  input  logic                prog_done,
  input  logic [BYTE_W-1:0]   rd_byte,
  output logic                sda_oe,
  output logic                wr_req,
  output logic [CODE_W-1:0]   wr_byte,
  output logic                otp_req
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  frame_state_e        state_q, state_d;
  logic [CNT_W-1:0]    bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0]   shift_q, shift_d;
  logic                rw_q, rw_d, tbit_q, tbit_d, first_q, first_d;
  logic                oe_q, oe_d, mack_q, mack_d, otp_q, otp_d;

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shift_d  = shift_q;
    rw_d     = rw_q;
    tbit_d   = tbit_q;
    first_d  = first_q;
    oe_d     = oe_q;
    mack_d   = mack_q;
    otp_d    = 1'b0;
    wr_req   = 1'b0;
    if (start_det) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise && bitcnt_q != FULL) begin
            shift_d  = {shift_q[BYTE_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == FULL) begin
            bitcnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (shift_q[7:1] == {ADDR_PREFIX, addr_sel}) begin
                oe_d    = 1'b1;
                rw_d    = shift_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_INSTR) begin
              oe_d    = 1'b1;
              tbit_d  = shift_q[7];
              first_d = 1'b1;
              state_d = ST_INSTR_ACK;
            end else begin
              oe_d    = 1'b1;
              wr_req  = 1'b1;
              state_d = ST_DATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (rw_q) begin
            shift_d  = rd_byte;
            oe_d     = ~rd_byte[BYTE_W-1];
            bitcnt_d = '0;
            state_d  = ST_TX;
          end else begin
            oe_d    = 1'b0;
            state_d = ST_INSTR;
          end
        end
        ST_INSTR_ACK: if (scl_fall) begin
          oe_d    = 1'b0;
          state_d = ST_DATA;
        end
        ST_DATA_ACK: if (scl_fall) begin
          oe_d    = 1'b0;
          state_d = ST_DATA;
          otp_d   = tbit_q & first_q & ~prog_done;
          first_d = 1'b0;
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt_q == FULL) begin
              oe_d    = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              shift_d = {shift_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shift_q[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = sda_s;
          end else if (scl_fall) begin
            if (!mack_q) begin
              shift_d  = rd_byte;
              oe_d     = ~rd_byte[BYTE_W-1];
              bitcnt_d = '0;
              state_d  = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shift_q  <= '0;
      rw_q     <= 1'b0;
      tbit_q   <= 1'b0;
      first_q  <= 1'b0;
      oe_q     <= 1'b0;
      mack_q   <= 1'b1;
      otp_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shift_q  <= shift_d;
      rw_q     <= rw_d;
      tbit_q   <= tbit_d;
      first_q  <= first_d;
      oe_q     <= oe_d;
      mack_q   <= mack_d;
      otp_q    <= otp_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_byte = shift_q[CODE_W-1:0];
  assign otp_req = otp_q;
endmodule

// File: rtl/trim_i2c_store.sv
module trim_i2c_store #(
  parameter int unsigned CODE_W     = 6,
  parameter logic [CODE_W-1:0] RESET_CODE = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [CODE_W-1:0] wr_byte,
  input  logic              prog_done,
  output logic [CODE_W-1:0] code_q,
  output logic              stb_q
);
  logic              load_en;
  logic [CODE_W-1:0] code_d;

  assign load_en = wr_req & ~prog_done;
  assign code_d  = load_en ? wr_byte : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RESET_CODE;
      stb_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      stb_q  <= load_en;
    end
  end
endmodule

// File: rtl/trim_i2c_slave.sv
module trim_i2c_slave
  import trim_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  ADDR_PREFIX = 6'b010110,
  parameter logic [5:0]  RESET_CODE  = 6'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  input  logic [1:0] status_i,
  input  logic       prog_done_i,
  output logic       sda_oe,
  output logic [5:0] trim_code,
  output logic       wr_stb,
  output logic       otp_start
);
  localparam int unsigned CODE_W = 6;

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_req;
  logic [CODE_W-1:0] wr_bus;
  logic [BYTE_W-1:0] rd_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign rd_byte = {status_i, trim_code};

  trim_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  trim_i2c_frame #(.ADDR_PREFIX(ADDR_PREFIX), .CODE_W(CODE_W)) u_frame (
    .clk(clk), .rst_n(rst_core_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .prog_done(prog_done_i), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_req(wr_req), .wr_byte(wr_bus), .otp_req(otp_start)
  );

  trim_i2c_store #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_store (
    .clk(clk), .rst_n(rst_core_n), .wr_req(wr_req), .wr_byte(wr_bus),
    .prog_done(prog_done_i), .code_q(trim_code), .stb_q(wr_stb)
  );
endmodule

// File: rtl/trim_i2c_slave_chk.sv
module trim_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       prog_done_i,
  input logic       sda_oe,
  input logic [5:0] trim_code,
  input logic       wr_stb,
  input logic       otp_start,
  input logic [5:0] wr_bus
);
  // R2
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> trim_code == $past(wr_bus));

  // R6
  otp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otp_start |=> !otp_start);

  // R6
  otp_not_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otp_start |-> !wr_stb);

  // R7
  lock_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prog_done_i) |-> $stable(trim_code));

  // R7
  lock_otp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prog_done_i) |-> !otp_start);
endmodule

bind trim_i2c_slave trim_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .prog_done_i(prog_done_i),
  .sda_oe(sda_oe), .trim_code(trim_code), .wr_stb(wr_stb),
  .otp_start(otp_start), .wr_bus(wr_bus)
);

// File: tb/test_trim_i2c_slave.sv
module test_trim_i2c_slave;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic [1:0] status_i = 2'b00;
  logic       prog_done_i = 1'b0;
  logic       sda_oe, wr_stb, otp_start;
  logic [5:0] trim_code;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  int grace = 0, mon_on = 0;
  int wr_total = 0, otp_total = 0, otp_wr_snap = 0;
  int exp_trim = 32;
  bit done = 0;

  always #5 clk = ~clk;

  trim_i2c_slave i_trim_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .status_i(status_i), .prog_done_i(prog_done_i),
    .sda_oe(sda_oe), .trim_code(trim_code), .wr_stb(wr_stb), .otp_start(otp_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model of the trim code, compared every clock
  always @(negedge clk) begin
    if (mon_on != 0) begin
      if (grace > 0) grace--;
      else chk(trim_code == exp_trim[5:0], "R3/R4 trim_code", trim_code, exp_trim);
      if (wr_stb) wr_total++;
      if (otp_start) begin
        otp_total++;
        otp_wr_snap = wr_total;
      end
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask
  task automatic i2c_start();
    sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half();
  endtask
  task automatic i2c_stop();
    sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half();
  endtask
  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; half(); scl_m = 1; half(); seen = sda_line; scl_m = 0;
  endtask

  // upd: the model expects the low six bits to be loaded
  task automatic send_byte(input logic [7:0] b, input bit upd, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    if (upd) begin
      grace = 8;
      exp_trim = b[5:0];
    end
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic read_byte(output logic [7:0] v, input logic master_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(master_ack, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit a;
    int w0, o0;
    logic s;
    logic [7:0] rv;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(trim_code == 6'h20, "R9 trim reset", trim_code, 32);
    chk(!sda_oe && !wr_stb && !otp_start, "R9 outputs idle", {sda_oe, wr_stb, otp_start}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R1 R2 R3: matching address, noisy ignored bits
    w0 = wr_total;
    i2c_start();
    send_byte(8'h58, 0, a); chk(a, "R1 address ack", a, 1);
    half(); chk(!sda_oe, "R2 release after ack", sda_oe, 0);
    send_byte(8'h7F, 0, a); chk(a, "R2 instruction ack", a, 1);
    send_byte(8'hC5, 1, a); chk(a, "R2 data ack", a, 1);
    // R4 streaming
    send_byte(8'h3A, 1, a);
    send_byte(8'h11, 1, a);
    i2c_stop(); half();
    chk(trim_code == 6'h11, "R4 last stream value", trim_code, 6'h11);
    chk(wr_total - w0 == 3, "R4 strobe per byte", wr_total - w0, 3);
    chk(otp_total == 0, "R6 no launch when bit7 clear", otp_total, 0);

    // R1 other address (bit1 set) is ignored
    w0 = wr_total;
    i2c_start();
    send_byte(8'h5A, 0, a); chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h00, 0, a);
    send_byte(8'h3F, 0, a); chk(!a, "R1 no ack after mismatch", a, 0);
    i2c_stop(); half();
    chk(wr_total == w0, "R1 no write on mismatch", wr_total - w0, 0);

    // R5 read with two status patterns
    status_i = 2'b10;
    i2c_start();
    send_byte(8'h59, 0, a); chk(a, "R5 read address ack", a, 1);
    read_byte(rv, 1'b1);
    chk(rv == {2'b10, 6'h11}, "R5 read byte", rv, {2'b10, 6'h11});
    i2c_stop(); half();
    status_i = 2'b01;
    i2c_start();
    send_byte(8'h59, 0, a);
    read_byte(rv, 1'b1);
    chk(rv == {2'b01, 6'h11}, "R5 repeated read", rv, {2'b01, 6'h11});
    i2c_stop(); half();

    // R8 abort by repeated START mid byte
    w0 = wr_total;
    i2c_start();
    send_byte(8'h58, 0, a);
    send_byte(8'h00, 0, a);
    for (int i = 7; i >= 4; i--) clk_bit(1'(8'h25 >> i), s);
    i2c_start();
    send_byte(8'h58, 0, a); chk(a, "R8 address after restart", a, 1);
    send_byte(8'h00, 0, a);
    send_byte(8'h0C, 1, a);
    i2c_stop(); half();
    chk(wr_total - w0 == 1, "R8 no partial write on restart", wr_total - w0, 1);
    // R8 abort by STOP mid byte
    w0 = wr_total;
    i2c_start();
    send_byte(8'h58, 0, a);
    send_byte(8'h00, 0, a);
    for (int i = 7; i >= 5; i--) clk_bit(1'(8'h3B >> i), s);
    i2c_stop(); half();
    chk(wr_total == w0, "R8 no write on stop abort", wr_total - w0, 0);
    chk(trim_code == 6'h0C, "R8 code kept", trim_code, 6'h0C);

    // R6 programming request
    w0 = wr_total; o0 = otp_total;
    i2c_start();
    send_byte(8'h58, 0, a);
    send_byte(8'h80, 0, a);
    send_byte(8'h2A, 1, a);
    send_byte(8'h15, 1, a);
    i2c_stop(); half();
    chk(otp_total - o0 == 1, "R6 single launch", otp_total - o0, 1);
    chk(otp_wr_snap == w0 + 1, "R6 launch after first write", otp_wr_snap, w0 + 1);
    chk(trim_code == 6'h15, "R6 stream under program", trim_code, 6'h15);

    // R7 locked
    prog_done_i = 1;
    status_i = 2'b11;
    w0 = wr_total; o0 = otp_total;
    i2c_start();
    send_byte(8'h58, 0, a);
    send_byte(8'h80, 0, a);
    send_byte(8'h07, 0, a); chk(a, "R7 data still acked", a, 1);
    i2c_stop(); half();
    chk(wr_total == w0, "R7 no strobe when locked", wr_total - w0, 0);
    chk(otp_total == o0, "R7 no launch when locked", otp_total - o0, 0);
    i2c_start();
    send_byte(8'h59, 0, a);
    read_byte(rv, 1'b1);
    chk(rv == {2'b11, 6'h15}, "R7 R5 locked readback", rv, {2'b11, 6'h15});
    i2c_stop(); half();
    finish_run();
  end
endmodule